// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The controller arbitrates between one non-maskable request and a set of maskable sources: four external request pins, three timer requests and two DMA-channel requests. Each maskable source has its own 3-bit priority level, where 0 is the most urgent, and its own mask bit. The vector number of each source is fixed at design time. When the CPU acknowledges, the controller returns the vector of the source that won. That vector is the index the CPU uses to find the service routine.

The controller keeps one in-service bit per maskable source. A request reaches the CPU only if its level beats the most urgent level still in service. In fully nested operation the level must be strictly more urgent. In special fully nested operation an equal level also gets through, so a source can interrupt its own handler. Software writes an end-of-interrupt command to close the most urgent handler that is still in service.

Requests are latched on their rising edge. Software reaches all state through one small register port with a shared address.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_o` is low, the mask register reads all ones (every source blocked), every priority register reads 7, the mode register reads 0 (fully nested), and the pending and in-service registers read 0.
- R2: A request is latched as pending on its rising edge only. A request held high after it has been acknowledged does not pend again. `irq_o` rises on the second clock edge after the input is first sampled high.
- R3: A set mask bit keeps its source from `irq_o` and from winning, but the source's pending bit is still recorded. Clearing the mask lets the source through.
- R4: Among eligible sources, the lowest priority value wins. On a tie, the lower source index wins. Source indices run 0–3 for the external pins, 4–6 for the timers and 7–8 for the DMA channels.
- R5: An acknowledge sampled on a clock edge drives `vec_o` and a one-cycle `vec_valid_o` pulse on that same edge. A maskable winner returns vector VEC_BASE + index, which is 8 + index by default.
- R6: Acknowledging a maskable winner sets its in-service bit and clears its pending bit.
- R7: In fully nested mode (mode bit 0 = 0), a maskable source is eligible only if its level is strictly lower in value than the lowest level among the in-service sources.
- R8: In special fully nested mode (mode bit 0 = 1), a source whose level equals that in-service level is also eligible, including the source already in service.
- R9: Writing the end-of-interrupt address clears exactly one in-service bit: the one with the lowest level value, with the lower index winning a tie.
- R10: The non-maskable request is never masked and is not limited by in-service state. It wins over every maskable source and returns vector 2. It sets no in-service bit.
- R11: An acknowledge with no eligible source returns the spurious vector 7 with `vec_valid_o` high and leaves the pending and in-service state unchanged.
- R12: The register map is: 0 = mask (bit i for source i), 1 = mode (bit 0), 2 = end-of-interrupt (write only), 3 = in-service (read), 4 = pending (read), 16 + i = priority of source i (bits 2:0). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge latched |
| ext_req_i | input | N_EXT (4) | External maskable requests, sources 0–3 |
| tmr_req_i | input | N_TMR (3) | Timer requests, sources 4–6 |
| dma_req_i | input | N_DMA (2) | DMA channel requests, sources 7–8 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (5) | Register address for both read and write |
| wr_data_i | input | DATA_W (16) | Register write data |
| rd_data_o | output | DATA_W (16) | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_i | input | 1 | Interrupt acknowledge from the CPU, one cycle |
| vec_o | output | 8 | Vector type of the acknowledged source |
| vec_valid_o | output | 1 | `vec_o` is fresh in this cycle |

## Verification
A request edge sampled on clock edge k is pending after edge k, and `irq_o` reflects it after edge k+1. The bench therefore drives inputs on a falling edge and samples `irq_o` at the falling edge that follows the second rising edge. An acknowledge raised on a falling edge produces `vec_o` and `vec_valid_o` after the next rising edge, so the bench reads them at the falling edge right after. Mask, mode and end-of-interrupt writes act on their own rising edge, and `irq_o` is sampled one edge later. Register reads are combinational and are taken a short delay after `addr_i` is set.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int unsigned PRIO_W = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [PRIO_W:0]   ceil_t;

  localparam int unsigned A_MASK  = 0;
  localparam int unsigned A_MODE  = 1;
  localparam int unsigned A_EOI   = 2;
  localparam int unsigned A_INSVC = 3;
  localparam int unsigned A_PEND  = 4;
  localparam int unsigned A_PRIO0 = 16;

  // Vector type of maskable source idx
  function automatic logic [7:0] src_vector(input logic [7:0] base, input int unsigned idx);
    logic [31:0] wide;
    wide = 32'(idx);
    return base + wide[7:0];
  endfunction

  // Eligibility of a level against the in-service ceiling
  function automatic logic admit(input prio_t lvl, input ceil_t ceiling, input logic sfn);
    ceil_t l;
    l = {1'b0, lvl};
    return (l < ceiling) || (sfn && (l == ceiling));
  endfunction

endpackage

// File: rtl/prio_intc_pick.sv
module prio_intc_pick
  import prio_intc_pkg::*;
#(
  parameter int unsigned N     = 9,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand_i,
  input  prio_t            lvl_i [N],
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output prio_t            lvl_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '1;
    for (int i = 0; i < int'(N); i++) begin
      if (cand_i[i] && (!found_o || (lvl_i[i] < lvl_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end

  // R4: the pick is a candidate and no candidate is more urgent
  always_comb begin
    p_pick_is_cand_r4: assert (!found_o || cand_i[idx_o]);
    for (int i = 0; i < int'(N); i++) begin
      if (found_o && cand_i[i]) begin
        p_pick_is_best_r4: assert (lvl_o <= lvl_i[i]);
      end
    end
  end

endmodule

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int unsigned N      = 9,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      insvc_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N-1:0]      mask_o,
  output logic              sfn_o,
  output prio_t             lvl_o [N],
  output logic              eoi_o
);

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i;

  logic hit_mask, hit_mode;
  assign hit_mask = wr_en_i && (addr_i == ADDR_W'(A_MASK));
  assign hit_mode = wr_en_i && (addr_i == ADDR_W'(A_MODE));
  assign eoi_o    = wr_en_i && (addr_i == ADDR_W'(A_EOI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      sfn_o  <= 1'b0;
    end else begin
      if (hit_mask) mask_o <= wr_data_i[N-1:0];
      if (hit_mode) sfn_o  <= wr_data_i[0];
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_lvl
    logic hit_lvl;
    assign hit_lvl = wr_en_i && (addr_i == ADDR_W'(A_PRIO0 + g));
    always_ff @(posedge clk) begin
      if (!rst_n)       lvl_o[g] <= '1;
      else if (hit_lvl) lvl_o[g] <= wr_data_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(A_MASK))  rd_data_o = DATA_W'(mask_o);
    if (addr_i == ADDR_W'(A_MODE))  rd_data_o = DATA_W'(sfn_o);
    if (addr_i == ADDR_W'(A_INSVC)) rd_data_o = DATA_W'(insvc_i);
    if (addr_i == ADDR_W'(A_PEND))  rd_data_o = DATA_W'(pend_i);
    for (int i = 0; i < int'(N); i++) begin
      if (addr_i == ADDR_W'(A_PRIO0 + i)) rd_data_o = DATA_W'(lvl_o[i]);
    end
  end

  // R12: mode write lands on the next cycle
  p_mode_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mode |=> (sfn_o == $past(wr_data_i[0])));

  // R12: mask write lands on the next cycle
  p_mask_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mask |=> (mask_o == $past(wr_data_i[N-1:0])));

endmodule

// File: rtl/prio_intc_svc.sv
module prio_intc_svc
  import prio_intc_pkg::*;
#(
  parameter int unsigned N        = 9,
  parameter int unsigned IDX_W    = $clog2(N),
  parameter logic [7:0]  VEC_BASE = 8'd8,
  parameter logic [7:0]  NMI_VEC  = 8'd2,
  parameter logic [7:0]  SPUR_VEC = 8'd7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         nmi_i,
  input  logic [N-1:0] mask_i,
  input  logic         sfn_i,
  input  prio_t        lvl_i [N],
  input  logic         ack_i,
  input  logic         eoi_i,
  output logic         irq_o,
  output logic [7:0]   vec_o,
  output logic         vec_valid_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] insvc_o
);

  logic [N-1:0] req_d, pend_q, is_q, elig;
  logic         nmi_d, nmi_pend_q;

  // Winner among eligible requests
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_lvl;

  // Most urgent in-service source
  logic             top_found;
  logic [IDX_W-1:0] top_idx;
  prio_t            top_lvl;
  ceil_t            ceiling;

  // Named internal events
  logic         ack_nmi, ack_src, ack_spur;
  logic [N-1:0] ack_set, eoi_clr, req_edge;

  assign ceiling  = top_found ? {1'b0, top_lvl} : {1'b1, {PRIO_W{1'b0}}};
  assign req_edge = req_i & ~req_d;

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      elig[i] = pend_q[i] && !mask_i[i] && admit(lvl_i[i], ceiling, sfn_i);
    end
  end

  prio_intc_pick #(.N(N), .IDX_W(IDX_W)) u_win (
    .cand_i  (elig),
    .lvl_i   (lvl_i),
    .found_o (win_found),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  prio_intc_pick #(.N(N), .IDX_W(IDX_W)) u_top (
    .cand_i  (is_q),
    .lvl_i   (lvl_i),
    .found_o (top_found),
    .idx_o   (top_idx),
    .lvl_o   (top_lvl)
  );

  assign ack_nmi  = ack_i && nmi_pend_q;
  assign ack_src  = ack_i && !nmi_pend_q && win_found;
  assign ack_spur = ack_i && !nmi_pend_q && !win_found;

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (ack_src)              ack_set[win_idx] = 1'b1;
    if (eoi_i && top_found)   eoi_clr[top_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d       <= '0;
      nmi_d       <= 1'b0;
      pend_q      <= '0;
      nmi_pend_q  <= 1'b0;
      is_q        <= '0;
      irq_o       <= 1'b0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      req_d       <= req_i;
      nmi_d       <= nmi_i;
      pend_q      <= (pend_q & ~ack_set) | req_edge;
      nmi_pend_q  <= (nmi_pend_q && !ack_nmi) || (nmi_i && !nmi_d);
      is_q        <= (is_q & ~eoi_clr) | ack_set;
      irq_o       <= (nmi_pend_q || win_found) && !ack_i;
      vec_valid_o <= ack_i;
      if (ack_nmi)       vec_o <= NMI_VEC;
      else if (ack_src)  vec_o <= src_vector(VEC_BASE, 32'(win_idx));
      else if (ack_spur) vec_o <= SPUR_VEC;
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = is_q;

  // R6: acknowledged maskable winner becomes in service
  p_ack_sets_is_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_src |=> is_q[$past(win_idx)]);

  // R10: NMI acknowledge returns the NMI vector and touches no in-service bit
  p_nmi_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_nmi && !eoi_i) |=> (vec_valid_o && (vec_o == NMI_VEC) && $stable(is_q)));

  // R5: a vector pulse always follows an acknowledge
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_i));

  // R7: fully nested admits only strictly more urgent levels
  p_fnm_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_found && top_found && !sfn_i) |-> (win_lvl < top_lvl));

  // R8: special fully nested never admits a less urgent level
  p_sfnm_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_found && top_found && sfn_i) |-> (win_lvl <= top_lvl));

  // R9: end-of-interrupt removes exactly one in-service bit
  p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && top_found && !ack_i) |=> ($countones(is_q) == $countones($past(is_q)) - 1));

  // R11: spurious acknowledge leaves in-service state alone
  p_spur_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !eoi_i) |=> ($stable(is_q) && (vec_o == SPUR_VEC)));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned N_EXT    = 4,
  parameter int unsigned N_TMR    = 3,
  parameter int unsigned N_DMA    = 2,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter logic [7:0]  VEC_BASE = 8'd8,
  parameter logic [7:0]  NMI_VEC  = 8'd2,
  parameter logic [7:0]  SPUR_VEC = 8'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_TMR-1:0]  tmr_req_i,
  input  logic [N_DMA-1:0]  dma_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic [7:0]        vec_o,
  output logic              vec_valid_o
);

  localparam int unsigned N_SRC = N_EXT + N_TMR + N_DMA;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] all_req, mask, pend, insvc;
  logic             sfn, eoi;
  prio_t            lvl [N_SRC];

  assign all_req = {dma_req_i, tmr_req_i, ext_req_i};

  prio_intc_regs #(.N(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .pend_i    (pend),
    .insvc_i   (insvc),
    .rd_data_o (rd_data_o),
    .mask_o    (mask),
    .sfn_o     (sfn),
    .lvl_o     (lvl),
    .eoi_o     (eoi)
  );

  prio_intc_svc #(
    .N(N_SRC), .IDX_W(IDX_W),
    .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC), .SPUR_VEC(SPUR_VEC)
  ) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (all_req),
    .nmi_i       (nmi_i),
    .mask_i      (mask),
    .sfn_i       (sfn),
    .lvl_i       (lvl),
    .ack_i       (ack_i),
    .eoi_i       (eoi),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .pend_o      (pend),
    .insvc_o     (insvc)
  );

  // R3: an interrupt request never appears while nothing at all is pending
  p_irq_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pend != '0 || u_svc.nmi_pend_q));

endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 1'b0;
  logic [8:0]  src = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq, ack = 1'b0;
  logic [7:0]  vec;
  logic        vec_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi),
    .ext_req_i(src[3:0]), .tmr_req_i(src[6:4]), .dma_req_i(src[8:7]),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irq_o(irq), .ack_i(ack), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  // Source levels: index 0..8
  localparam int PRIO_CFG [9] = '{3, 5, 1, 1, 6, 2, 4, 0, 7};

  // {requests[26:18], mask[17:9], irq[8], vector[7:0]}
  localparam logic [26:0] VECS [10] = '{
    {9'h001, 9'h000, 1'b1, 8'd8},
    {9'h00C, 9'h000, 1'b1, 8'd10},
    {9'h181, 9'h000, 1'b1, 8'd15},
    {9'h181, 9'h080, 1'b1, 8'd8},
    {9'h022, 9'h000, 1'b1, 8'd13},
    {9'h008, 9'h008, 1'b0, 8'd7},
    {9'h1FF, 9'h000, 1'b1, 8'd15},
    {9'h1FF, 9'h080, 1'b1, 8'd10},
    {9'h050, 9'h000, 1'b1, 8'd14},
    {9'h000, 9'h000, 1'b0, 8'd7}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; nmi = 1'b0; ack = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 5'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic configure(input int m, input int mode);
    for (int i = 0; i < 9; i++) wr(16 + i, PRIO_CFG[i]);
    wr(0, m);
    wr(1, mode);
  endtask

  // Pulse requests; returns at the falling edge after the latching edge
  task automatic pulse(input logic [8:0] s, input logic n);
    @(negedge clk);
    src = s; nmi = n;
    @(negedge clk);
    src = '0; nmi = 1'b0;
  endtask

  task automatic wait1();
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;

    // R1: reset state
    do_reset();
    wait1();
    chk("R1 irq", int'(irq), 0);
    rd(0, d); chk("R1 mask", d, 16'h01FF);
    rd(1, d); chk("R1 mode", d, 0);
    rd(19, d); chk("R1 prio3", d, 7);
    rd(3, d); chk("R1 insvc", d, 0);
    rd(4, d); chk("R1 pend", d, 0);

    // Table walk: R4, R3, R5, R11
    for (int v = 0; v < 10; v++) begin
      do_reset();
      configure(int'(VECS[v][17:9]), 0);
      pulse(VECS[v][26:18], 1'b0);
      wait1();
      chk($sformatf("R4 vec%0d irq", v), int'(irq), int'(VECS[v][8]));
      do_ack();
      chk($sformatf("R5 vec%0d vector", v), int'(vec), int'(VECS[v][7:0]));
      chk($sformatf("R5 vec%0d valid", v), int'(vec_valid), 1);
    end
    wait1();
    chk("R5 valid drops", int'(vec_valid), 0);

    // R2: held request pends once
    do_reset();
    configure(0, 0);
    @(negedge clk); src = 9'h001;
    wait1(); wait1();
    chk("R2 irq timing", int'(irq), 1);
    do_ack();
    chk("R2 vector", int'(vec), 8);
    wait1(); wait1(); wait1();
    rd(4, d); chk("R2 no repend", d, 0);
    chk("R2 irq low", int'(irq), 0);
    src = '0;
    rd(3, d); chk("R6 insvc set", d, 1);
    wr(2, 0);
    rd(3, d); chk("R9 eoi clears", d, 0);

    // R3: masked source still pends
    wr(0, 16'h0002);
    pulse(9'h002, 1'b0);
    wait1();
    chk("R3 masked irq", int'(irq), 0);
    rd(4, d); chk("R3 pend kept", d, 2);
    wr(0, 0);
    wait1();
    chk("R3 unmasked irq", int'(irq), 1);
    do_ack();
    chk("R3 vector", int'(vec), 9);
    rd(3, d); chk("R6 insvc src1", d, 2);
    rd(4, d); chk("R6 pend cleared", d, 0);

    // R7: fully nested
    pulse(9'h020, 1'b0); wait1();
    chk("R7 higher passes", int'(irq), 1);
    do_ack(); chk("R7 vector src5", int'(vec), 13);
    pulse(9'h020, 1'b0); wait1();
    chk("R7 equal blocked", int'(irq), 0);
    pulse(9'h001, 1'b0); wait1();
    chk("R7 lower blocked", int'(irq), 0);
    rd(4, d); chk("R7 pend", d, 16'h021);
    pulse(9'h080, 1'b0); wait1();
    chk("R7 top passes", int'(irq), 1);
    do_ack(); chk("R7 vector src7", int'(vec), 15);
    rd(3, d); chk("R6 insvc nested", d, 16'h0A2);
    wr(2, 0);
    rd(3, d); chk("R9 eoi top", d, 16'h022);
    wait1();
    chk("R9 still blocked", int'(irq), 0);
    wr(2, 0);
    rd(3, d); chk("R9 eoi next", d, 16'h002);
    wait1();
    chk("R4 after eoi irq", int'(irq), 1);
    do_ack(); chk("R4 after eoi vector", int'(vec), 13);

    // R8: special fully nested
    wr(1, 1);
    pulse(9'h020, 1'b0); wait1();
    chk("R8 equal passes", int'(irq), 1);
    do_ack(); chk("R8 self vector", int'(vec), 13);
    rd(3, d); chk("R8 insvc", d, 16'h022);

    // R10: NMI
    pulse(9'h000, 1'b1); wait1();
    chk("R10 irq", int'(irq), 1);
    do_ack(); chk("R10 vector", int'(vec), 2);
    rd(3, d); chk("R10 insvc untouched", d, 16'h022);
    wr(0, 16'h01FF);
    pulse(9'h080, 1'b1);
    do_ack(); chk("R10 masked all vector", int'(vec), 2);
    wr(0, 0);
    wait1();
    do_ack(); chk("R10 then src7", int'(vec), 15);

    // R11: spurious acknowledge
    do_reset();
    wait1();
    do_ack();
    chk("R11 vector", int'(vec), 7);
    chk("R11 valid", int'(vec_valid), 1);
    rd(3, d); chk("R11 insvc", d, 0);
    rd(4, d); chk("R11 pend", d, 0);

    // R12: register map
    wr(24, 0);
    rd(24, d); chk("R12 prio8", d, 0);
    rd(5, d);  chk("R12 unmapped", d, 0);
    rd(25, d); chk("R12 beyond prio", d, 0);
    wr(0, 16'h0080);
    rd(0, d);  chk("R12 mask rb", d, 16'h0080);
    wr(23, 0);
    pulse(9'h180, 1'b0); wait1();
    do_ack(); chk("R4 reprogrammed prio", int'(vec), 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule